// File: doc/BRIEF.md
# Frame Phase Lock Controller with Line Slip

This block keeps a video timing generator's internal frame in step with the frame of an incoming composite sync signal. The surrounding design supplies three one-cycle strobes: the start of each internal frame, the start of each external frame (already separated from the incoming sync), and the end of each line. A two-bit mode input selects the behaviour. In the two slow modes the block measures how far apart the two frame starts are, in whole lines, each time an external frame begins. If they differ it tells the internal frame generator to lengthen or shorten the frame in progress by exactly one line, so the phase error closes by one line per frame. In the fast mode it passes each external frame start on as a reset strobe for the internal frame counter. In the subcarrier mode it does nothing.

The block measures the error by counting line-end strobes since the last internal frame start. A count of zero at an external frame start means the two frames are aligned. A small count means the internal frame is ahead and gets an extra line. A count above half a frame means the external frame leads and the internal frame loses a line. The lock flag reports two consecutive aligned measurements. It drops on a misaligned measurement, or after several internal frames pass with no external frame start at all.

The internal frame generator must apply a command to the frame in progress. If the command arrives during that frame's final line, the generator applies it to the following frame instead.

Top module: `frame_lock_ctrl`

## Requirements
- R1: Mode 2'b00 (subcarrier): addLine, dropLine and frameReset stay low, and locked is held low.
- R2: In modes 2'b01 and 2'b10 (slow lock; the two differ only in the line reference, which lies outside this block), each accepted external frame start is compared with the internal frame phase. The phase error is the number of lineEnd strobes since the last intFrameStart, and is zero when both starts arrive in the same cycle. An error of zero produces no command.
- R3: A nonzero error E issues a one-cycle command in the cycle after the external frame start. The command is dropLine when E > LINES_PER_FRAME/2 and addLine when 1 <= E <= LINES_PER_FRAME/2.
- R4: addLine and dropLine are never high together. Each follows an external frame start by one cycle. At most one is issued per internal frame, because further external starts within the same internal frame are ignored.
- R5: Mode 2'b11 (fast lock): frameReset pulses for one cycle, one cycle after each external frame start, and no add or drop command is issued.
- R6: In modes other than 2'b00, locked rises after LOCK_FRAMES consecutive aligned measurements and falls right after a misaligned one.
- R7: An internal frame start with no external start accepted in the frame just ended counts as a missed frame. After MISS_FRAMES consecutive misses, locked falls.
- R8: In closed loop with a generator that obeys the commands, any initial offset reaches lock within LINES_PER_FRAME/2 + LOCK_FRAMES + 2 frames. At 625 lines and 50 frames/s this is about 6.3 s, of which about 6.24 s is slip.
- R9: After reset all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lockMode | input | 2 | 00 subcarrier, 01/10 slow lock, 11 fast lock |
| lineEnd | input | 1 | One-cycle strobe at the end of each line |
| intFrameStart | input | 1 | One-cycle strobe at the start of an internal frame |
| extFramePulse | input | 1 | One-cycle strobe at the start of an external frame |
| addLine | output | 1 | Lengthen the current internal frame by one line |
| dropLine | output | 1 | Shorten the current internal frame by one line |
| frameReset | output | 1 | Reset the internal frame counter (fast mode) |
| locked | output | 1 | Frames aligned for the required number of frames |

## Verification
Assertions check every cycle that the two commands never overlap and only follow an external frame start. They also check that fast mode issues no command and resets only after an external pulse, that subcarrier mode stays silent, and that the lock flag falls only at a frame event or a mode change. The choice of direction at the half-frame boundary, the exact frame counts for gaining and losing lock, and convergence in closed loop with a slipping frame generator can only be shown by the bench's scenarios.

// File: rtl/flk_pkg.sv
package flk_pkg;

  typedef enum logic [1:0] {
    MODE_SUBCARRIER = 2'b00,
    MODE_SLOW_EXTREF = 2'b01,
    MODE_SLOW_INTREF = 2'b10,
    MODE_FAST = 2'b11
  } lockMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearPhase;
    logic lineStep;
  } dpStrobe_t;

endpackage

// File: rtl/flk_datapath.sv
module flk_datapath
  import flk_pkg::*;
#(
  parameter int LINES_PER_FRAME = 625
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  output logic      offsetAligned,
  output logic      dropDir
);

  localparam int CNT_W = $clog2(LINES_PER_FRAME + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] HALF_LINES = CNT_W'(LINES_PER_FRAME / 2);

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] offsetNow;

  // Lines elapsed since the internal frame began
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strobe.clearPhase) begin
      phaseCnt <= '0;
    end else if (strobe.lineStep && (phaseCnt != CNT_MAX)) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // A frame start in this cycle means zero error
  always_comb begin
    offsetNow     = strobe.clearPhase ? '0 : phaseCnt;
    offsetAligned = (offsetNow == '0);
    dropDir       = (offsetNow > HALF_LINES);
  end

  // R2: the phase count only moves on a line or frame strobe
  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strobe.clearPhase) && !$past(strobe.lineStep)) |-> $stable(phaseCnt));

endmodule

// File: rtl/flk_control.sv
module flk_control
  import flk_pkg::*;
#(
  parameter int MISS_FRAMES = 3,
  parameter int LOCK_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lockMode,
  input  logic       lineEnd,
  input  logic       intFrameStart,
  input  logic       extFramePulse,
  input  logic       offsetAligned,
  input  logic       dropDir,
  output dpStrobe_t  strobe,
  output logic       addLine,
  output logic       dropLine,
  output logic       frameReset,
  output logic       locked
);

  localparam int MISS_W = $clog2(MISS_FRAMES + 1);
  localparam int MATCH_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [MISS_W-1:0] MISS_LIMIT = MISS_W'(MISS_FRAMES);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_FRAMES - 1);
  localparam logic [MATCH_W-1:0] MATCH_LIMIT = MATCH_W'(LOCK_FRAMES);

  logic modeActive, slowMode, fastMode;
  logic judged, evalNow, missedFrame;
  logic [MISS_W-1:0] missCnt;
  logic [MATCH_W-1:0] matchCnt;

  always_comb begin
    modeActive  = (lockMode != MODE_SUBCARRIER);
    slowMode    = (lockMode == MODE_SLOW_EXTREF) || (lockMode == MODE_SLOW_INTREF);
    fastMode    = (lockMode == MODE_FAST);
    // One judgement per internal frame; a start in the same cycle opens a new frame
    evalNow     = extFramePulse && modeActive && (!judged || intFrameStart);
    missedFrame = intFrameStart && !judged && !extFramePulse;
    strobe.clearPhase = intFrameStart;
    strobe.lineStep   = lineEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addLine    <= 1'b0;
      dropLine   <= 1'b0;
      frameReset <= 1'b0;
      judged     <= 1'b0;
      missCnt    <= '0;
      matchCnt   <= '0;
    end else begin
      addLine    <= evalNow && slowMode && !offsetAligned && !dropDir;
      dropLine   <= evalNow && slowMode && !offsetAligned && dropDir;
      frameReset <= extFramePulse && fastMode;
      if (!modeActive) begin
        judged   <= 1'b0;
        missCnt  <= '0;
        matchCnt <= '0;
      end else begin
        if (intFrameStart) begin
          judged <= evalNow;
        end else if (evalNow) begin
          judged <= 1'b1;
        end
        if (evalNow) begin
          missCnt <= '0;
          if (!offsetAligned) begin
            matchCnt <= '0;
          end else if (matchCnt != MATCH_LIMIT) begin
            matchCnt <= matchCnt + 1'b1;
          end
        end else if (missedFrame) begin
          if (missCnt != MISS_LIMIT) begin
            missCnt <= missCnt + 1'b1;
          end
          if (missCnt >= MISS_LAST) begin
            matchCnt <= '0;
          end
        end
      end
    end
  end

  assign locked = (matchCnt == MATCH_LIMIT);

  // R4: never both commands
  assert_one_cmd_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(addLine && dropLine));

  // R4: a command follows an external frame start
  assert_cmd_after_ext_R4: assert property (@(posedge clk) disable iff (!rstN)
    (addLine || dropLine) |-> $past(extFramePulse));

  // R1: subcarrier mode is silent
  assert_sub_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lockMode) == MODE_SUBCARRIER) |-> (!addLine && !dropLine && !frameReset && !locked));

  // R5: reset strobe only after an external pulse in fast mode
  assert_fast_reset_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameReset |-> ($past(extFramePulse) && ($past(lockMode) == MODE_FAST)));

  // R5: fast mode never slips lines
  assert_fast_nocmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lockMode) == MODE_FAST) |-> (!addLine && !dropLine));

  // R6, R7: lock lost only at a frame event or mode change
  assert_lock_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> ($past(extFramePulse) || $past(intFrameStart) ||
                       ($past(lockMode) == MODE_SUBCARRIER)));

endmodule

// File: rtl/frame_lock_ctrl.sv
module frame_lock_ctrl
  import flk_pkg::*;
#(
  parameter int LINES_PER_FRAME = 625,
  parameter int MISS_FRAMES = 3,
  parameter int LOCK_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lockMode,
  input  logic       lineEnd,
  input  logic       intFrameStart,
  input  logic       extFramePulse,
  output logic       addLine,
  output logic       dropLine,
  output logic       frameReset,
  output logic       locked
);

  dpStrobe_t strobe;
  logic offsetAligned;
  logic dropDir;

  flk_datapath #(
    .LINES_PER_FRAME(LINES_PER_FRAME)
  ) u_datapath (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .offsetAligned(offsetAligned),
    .dropDir(dropDir)
  );

  flk_control #(
    .MISS_FRAMES(MISS_FRAMES),
    .LOCK_FRAMES(LOCK_FRAMES)
  ) u_control (
    .clk(clk),
    .rstN(rstN),
    .lockMode(lockMode),
    .lineEnd(lineEnd),
    .intFrameStart(intFrameStart),
    .extFramePulse(extFramePulse),
    .offsetAligned(offsetAligned),
    .dropDir(dropDir),
    .strobe(strobe),
    .addLine(addLine),
    .dropLine(dropLine),
    .frameReset(frameReset),
    .locked(locked)
  );

endmodule

// File: tb/frame_lock_ctrl_tb.sv
module frame_lock_ctrl_tb;

  localparam int L = 16;
  localparam int MISS = 3;
  localparam int LOCKN = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] lockMode = 2'b00;
  logic lineEnd = 1'b0;
  logic intFrameStart = 1'b0;
  logic extFramePulse = 1'b0;
  logic addLine, dropLine, frameReset, locked;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  frame_lock_ctrl #(
    .LINES_PER_FRAME(L),
    .MISS_FRAMES(MISS),
    .LOCK_FRAMES(LOCKN)
  ) u_dut (
    .clk(clk), .rstN(rstN), .lockMode(lockMode), .lineEnd(lineEnd),
    .intFrameStart(intFrameStart), .extFramePulse(extFramePulse),
    .addLine(addLine), .dropLine(dropLine), .frameReset(frameReset), .locked(locked)
  );

  always #10 clk = ~clk;

  // Vector: mode[10:9] offset[8:4] pad[3] add[2] drop[1] reset[0]
  localparam int NV = 10;
  localparam logic [10:0] VEC [NV] = '{
    {2'd2, 5'd3,  1'b0, 1'b1, 1'b0, 1'b0},
    {2'd2, 5'd13, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd1, 5'd8,  1'b0, 1'b1, 1'b0, 1'b0},
    {2'd1, 5'd9,  1'b0, 1'b0, 1'b1, 1'b0},
    {2'd2, 5'd1,  1'b0, 1'b1, 1'b0, 1'b0},
    {2'd1, 5'd15, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd2, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    {2'd0, 5'd5,  1'b0, 1'b0, 1'b0, 1'b0},
    {2'd3, 5'd5,  1'b0, 1'b0, 1'b0, 1'b1},
    {2'd3, 5'd0,  1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic le, input logic is, input logic ep);
    @(negedge clk);
    lineEnd = le;
    intFrameStart = is;
    extFramePulse = ep;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    lineEnd = 0; intFrameStart = 0; extFramePulse = 0;
    repeat (2) @(posedge clk);
    #1;
    rstN = 1'b1;
  endtask

  // One frame: start (optional coincident ext) then L lines, ext at line extLine
  task automatic frameBody(input int extLine);
    for (int ln = 1; ln <= L; ln++) begin
      step(1, 0, 0);
      if (ln < L) step(0, 0, extLine == ln);
    end
  endtask

  task automatic runRow(input logic [1:0] m, input int off,
                        output logic sawAdd, output logic sawDrop, output logic sawRst);
    sawAdd = 0; sawDrop = 0; sawRst = 0;
    lockMode = m;
    step(0, 1, off == 0);
    sawAdd |= addLine; sawDrop |= dropLine; sawRst |= frameReset;
    for (int ln = 1; ln <= L; ln++) begin
      step(1, 0, 0);
      sawAdd |= addLine; sawDrop |= dropLine; sawRst |= frameReset;
      if (ln < L) begin
        step(0, 0, off == ln);
        sawAdd |= addLine; sawDrop |= dropLine; sawRst |= frameReset;
      end
    end
  endtask

  // Closed loop: bench generator obeys commands
  task automatic converge(input logic [1:0] m, input int initOff);
    int intPos = 0;
    int intLen = L;
    int nextAdj = 0;
    int extPos = (L - initOff) % L;
    int frames = 0;
    int stray = 0;
    int perFrame = 0;
    int maxPerFrame = 0;
    bit done = 0;
    lockMode = m;
    for (int k = 0; k < 40 * L && !done; k++) begin
      step(1, 0, 0);
      if (addLine || dropLine) stray++;
      step(0, intPos == 0, extPos == 0);
      if (intPos == 0) begin
        frames++;
        perFrame = 0;
      end
      if (addLine || dropLine) begin
        int delta = addLine ? 1 : -1;
        perFrame++;
        if (perFrame > maxPerFrame) maxPerFrame = perFrame;
        if (intPos < intLen - 1) intLen += delta;
        else nextAdj = delta;
      end
      if (locked) done = 1;
      intPos++;
      if (intPos >= intLen) begin
        intPos = 0;
        intLen = L + nextAdj;
        nextAdj = 0;
      end
      extPos = (extPos + 1) % L;
    end
    check(done, "R8", $sformatf("lock reached from offset %0d", initOff), done, 1);
    check(frames <= L / 2 + LOCKN + 2, "R8", $sformatf("frames to lock from offset %0d", initOff),
          frames, L / 2 + LOCKN + 2);
    check(stray == 0, "R4", "command not after ext start", stray, 0);
    check(maxPerFrame <= 1, "R4", "commands per frame", maxPerFrame, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic sa, sd, sr;
    string tag;
    doReset();
    // R9 reset state
    check({addLine, dropLine, frameReset, locked} == 4'b0, "R9", "outputs after reset",
          {addLine, dropLine, frameReset, locked}, 0);

    // Vector table: R1, R3, R5
    for (int v = 0; v < NV; v++) begin
      runRow(VEC[v][10:9], int'(VEC[v][8:4]), sa, sd, sr);
      tag = (VEC[v][10:9] == 2'd0) ? "R1" : (VEC[v][10:9] == 2'd3) ? "R5" :
            (VEC[v][8:4] == 5'd0) ? "R2" : "R3";
      check({sa, sd, sr} == VEC[v][2:0], tag,
            $sformatf("row %0d add/drop/reset", v), {sa, sd, sr}, VEC[v][2:0]);
    end
    check(locked == 1'b0, "R1", "locked in subcarrier path", locked, 0);

    // R2/R3 timing: command exactly one cycle after ext, then gone
    doReset();
    lockMode = 2'b10;
    step(0, 1, 0);
    for (int ln = 1; ln <= 4; ln++) step(1, 0, 0);
    step(0, 0, 1);
    check(addLine == 1'b1 && dropLine == 1'b0, "R3", "add one cycle after ext", addLine, 1);
    step(0, 0, 0);
    check(addLine == 1'b0, "R3", "add lasts one cycle", addLine, 0);
    // R4: second ext in same internal frame ignored
    step(1, 0, 0);
    step(0, 0, 1);
    check(addLine == 1'b0 && dropLine == 1'b0, "R4", "second ext same frame", addLine | dropLine, 0);

    // R6: lock after two aligned frames, lost on misalignment
    doReset();
    lockMode = 2'b01;
    step(0, 1, 1);
    check(locked == 1'b0, "R6", "locked after one aligned", locked, 0);
    frameBody(-1);
    step(0, 1, 1);
    check(locked == 1'b1, "R6", "locked after two aligned", locked, 1);
    step(0, 0, 0);
    for (int ln = 1; ln <= 4; ln++) step(1, 0, 0);
    step(0, 1, 0);
    frameBody(4);
    check(locked == 1'b0 && addLine == 1'b0, "R6", "lock lost after misaligned", locked, 0);

    // R7: missing external frames
    doReset();
    lockMode = 2'b10;
    step(0, 1, 1); frameBody(-1);
    step(0, 1, 1); frameBody(-1);
    step(0, 1, 0); frameBody(-1);
    step(0, 1, 0); frameBody(-1);
    step(0, 1, 0);
    check(locked == 1'b1, "R7", "locked after two misses", locked, 1);
    check(addLine == 1'b0 && dropLine == 1'b0, "R7", "no command on miss", addLine | dropLine, 0);
    frameBody(-1);
    step(0, 1, 0);
    check(locked == 1'b0, "R7", "lock lost after three misses", locked, 0);

    // R5: fast mode pulse width and timing
    doReset();
    lockMode = 2'b11;
    step(1, 0, 1);
    check(frameReset == 1'b1, "R5", "reset one cycle after ext", frameReset, 1);
    step(0, 0, 0);
    check(frameReset == 1'b0, "R5", "reset lasts one cycle", frameReset, 0);

    // R1: subcarrier mode ignores external pulse at the outputs
    lockMode = 2'b00;
    step(0, 0, 1);
    check({addLine, dropLine, frameReset} == 3'b0, "R1", "subcarrier ignores ext",
          {addLine, dropLine, frameReset}, 0);

    // R8 closed loop, both directions incl. worst-case add
    doReset();
    converge(2'b01, 13);
    doReset();
    converge(2'b10, L / 2);
    doReset();
    converge(2'b01, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule